// File: doc/BRIEF.md
# Link Request Handler with PHY Register File

This block sits on the physical-layer side of a serial bus interface and acts on requests that the link layer has already decoded. Each cycle the decoder may present one request: a register write, a register read, or one of four bus-arbitration requests (fair, priority, isochronous, immediate). The block keeps a sixteen-entry, eight-bit PHY register file. It returns read data through a valid/ready response port to the status serializer. It also holds at most one pending bus request for the arbiter.

A pending bus request stays in place until a bus event cancels it. Packet reception and packet transmission cancel any kind. A subaction gap cancels only isochronous and immediate requests. A bus reset always clears it. While a request is pending, every further bus request is dropped. An accepted isochronous request also raises the accelerated-arbitration flag, which stays high until that request goes away. Register 0 carries the node's physical ID in its upper six bits. Only self-identification logic loads that field. Link writes reach only the two low bits.

Top module: `link_req_handler`

## Requirements
- R1: A register write (req_kind 0) to a nonzero address stores req_data in that register at the clock edge that accepts it, so a read issued in the next cycle returns the new value.
- R2: In register 0, bits [7:2] hold the physical ID and are loaded from selfid_id when selfid_load is high. A link write to address 0 changes only bits [1:0].
- R3: A read request (req_kind 1) with no response outstanding raises rsp_valid in the following cycle. rsp_addr and rsp_data then show the address and the register contents at the time of the request, and they hold until a cycle with rsp_ready high.
- R4: A read request that arrives while rsp_valid is high is dropped. proto_err pulses high for one cycle, and the outstanding response finishes with its original address and data.
- R5: When nothing is pending, a bus request (req_kind 2 fair, 3 priority, 4 isochronous, 5 immediate) makes pend_valid high in the next cycle, with pend_kind encoded 0 fair, 1 priority, 2 isochronous, 3 immediate.
- R6: While pend_valid is high, any further bus request is ignored, and pend_kind keeps its value.
- R7: ev_pkt_rx or ev_pkt_tx cancels a pending request of any kind. A bus request in the same cycle as the cancel is ignored.
- R8: ev_subgap cancels a pending isochronous or immediate request and leaves a fair or priority request pending.
- R9: ev_bus_reset clears pend_valid and accel_on in the next cycle, and it discards any bus request in the same cycle.
- R10: accel_on goes high with the acceptance of an isochronous request and drops when that request is cancelled. No other kind sets it.
- R11: req_kind values 6 and 7 change neither the register file, the response port nor the pending request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A decoded link request is present this cycle |
| req_kind | input | 3 | Request code: 0 write, 1 read, 2..5 bus requests |
| req_addr | input | 4 | Register address for write and read |
| req_data | input | 8 | Write data |
| ev_pkt_rx | input | 1 | Packet reception event |
| ev_pkt_tx | input | 1 | Packet transmission event |
| ev_subgap | input | 1 | Subaction gap detected |
| ev_bus_reset | input | 1 | Bus reset detected |
| selfid_load | input | 1 | Load the physical ID field of register 0 |
| selfid_id | input | 6 | Physical ID value |
| rsp_ready | input | 1 | Status serializer accepts the read response |
| rsp_valid | output | 1 | Read response available |
| rsp_addr | output | 4 | Address of the register being returned |
| rsp_data | output | 8 | Register contents being returned |
| proto_err | output | 1 | One-cycle pulse on an overlapping read |
| pend_valid | output | 1 | A bus request is pending |
| pend_kind | output | 2 | Kind of the pending bus request |
| accel_on | output | 1 | Accelerated arbitration enabled |

## Verification
The bench first runs a table of bus-request steps: second requests during a pending one, subaction gaps against each request kind, and requests that land in the same cycle as a cancel or a bus reset. A design that let a later request replace the pending one, let a gap cancel a fair request, or took a request at the cancel edge shows the wrong pend_valid or pend_kind there. Directed tests cover the register 0 split, because a write that reached the ID field would change a read-back. A response that tracked the live register instead of the captured value would change when the register is written while a response waits. An overlapping read that replaced the outstanding response would show a new address or data, or no proto_err pulse. The flag test checks that accel_on does not stay high after its isochronous request has gone.

// File: rtl/lrh_pkg.sv
// Shared encodings for the link request handler.
// Assumes the link-side decoder delivers one request code per cycle.
package lrh_pkg;

    typedef enum logic [2:0] {
        LK_WRITE = 3'd0,
        LK_READ  = 3'd1,
        LK_FAIR  = 3'd2,
        LK_PRI   = 3'd3,
        LK_ISO   = 3'd4,
        LK_IMM   = 3'd5
    } link_kind_e;

    typedef enum logic [1:0] {
        BK_FAIR = 2'd0,
        BK_PRI  = 2'd1,
        BK_ISO  = 2'd2,
        BK_IMM  = 2'd3
    } bus_kind_e;

endpackage

// File: rtl/lrh_regfile.sv
// PHY register file: 2**ADDR_W registers of DATA_W bits.
// Register 0 keeps the physical ID in its top PHYID_W bits; only the self-ID
// load writes that field, link writes reach the low bits only.
// Assumes at most one link write per cycle; reads are combinational.
module lrh_regfile #(
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 8,
    parameter int PHYID_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              id_load,
    input  logic [PHYID_W-1:0] id_value,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int NREG  = 1 << ADDR_W;
    localparam int LOW_W = DATA_W - PHYID_W;

    logic [DATA_W-1:0] regs [NREG];

    genvar g;
    generate
        for (g = 0; g < NREG; g++) begin : g_reg
            logic [DATA_W-1:0] q;
            logic [DATA_W-1:0] q_nxt;
            logic              hit;

            assign hit = wr_en && (wr_addr == ADDR_W'(g));

            if (g == 0) begin : g_id
                // Merge the link write into the low bits and the self-ID into the field.
                always_comb begin
                    q_nxt = q;
                    if (hit)
                        q_nxt[LOW_W-1:0] = wr_data[LOW_W-1:0];
                    if (id_load)
                        q_nxt[DATA_W-1:LOW_W] = id_value;
                end
            end else begin : g_plain
                // Plain register: take the whole write word.
                always_comb begin
                    q_nxt = hit ? wr_data : q;
                end
            end

            // Hold the register contents, cleared by reset.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= '0;
                else
                    q <= q_nxt;
            end

            assign regs[g] = q;
        end
    endgenerate

    assign rd_data = regs[rd_addr];

    AST_WR_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != '0) |=> regs[$past(wr_addr)] == $past(wr_data)); // R1

    AST_ID_FIELD_RO: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == '0 && !id_load) |=>
            $stable(regs[0][DATA_W-1:LOW_W])); // R2

endmodule

// File: rtl/lrh_readrsp.sv
// Read response stage: captures the register address and data when a read is
// accepted and offers them on a valid/ready port until taken.
// Assumes the status serializer may stall with rsp_ready low for any time.
module lrh_readrsp #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              rsp_ready,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic [DATA_W-1:0] rsp_data,
    output logic              proto_err
);

    // Capture a read when idle, retire it on handshake, flag overlapping reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_addr  <= '0;
            rsp_data  <= '0;
            proto_err <= 1'b0;
        end else begin
            proto_err <= rd_req && rsp_valid;
            if (rsp_valid) begin
                if (rsp_ready)
                    rsp_valid <= 1'b0;
            end else if (rd_req) begin
                rsp_valid <= 1'b1;
                rsp_addr  <= rd_addr;
                rsp_data  <= rd_data;
            end
        end
    end

    AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=>
            (rsp_valid && $stable(rsp_data) && $stable(rsp_addr))); // R3

    AST_RSP_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rsp_valid) |=> (rsp_valid && rsp_addr == $past(rd_addr))); // R3

    AST_OVERLAP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rsp_valid) |=> ($stable(rsp_addr) && proto_err)); // R4

endmodule

// File: rtl/lrh_busreq.sv
// Pending bus request holder with per-kind cancellation and the
// accelerated-arbitration flag.
// Assumes cancel events and a bus reset are single-cycle pulses.
module lrh_busreq
    import lrh_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      bus_req,
    input  bus_kind_e bus_kind,
    input  logic      ev_pkt_rx,
    input  logic      ev_pkt_tx,
    input  logic      ev_subgap,
    input  logic      ev_bus_reset,
    output logic      pend_valid,
    output bus_kind_e pend_kind,
    output logic      accel_on
);

    logic gap_kills;
    logic cancel;
    logic take;

    // Decide whether the pending request is cancelled this cycle.
    always_comb begin
        gap_kills = ev_subgap && (pend_kind == BK_ISO || pend_kind == BK_IMM);
        cancel    = pend_valid && (ev_pkt_rx || ev_pkt_tx || gap_kills);
        take      = !pend_valid && bus_req && !ev_bus_reset;
    end

    // Hold, cancel or accept the single pending request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_valid <= 1'b0;
            pend_kind  <= BK_FAIR;
        end else if (ev_bus_reset || cancel) begin
            pend_valid <= 1'b0;
        end else if (take) begin
            pend_valid <= 1'b1;
            pend_kind  <= bus_kind;
        end
    end

    // Accelerated arbitration follows an accepted isochronous request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            accel_on <= 1'b0;
        else if (ev_bus_reset || cancel)
            accel_on <= 1'b0;
        else if (take && bus_kind == BK_ISO)
            accel_on <= 1'b1;
    end

    AST_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend_valid && bus_req && !ev_bus_reset) |=>
            (pend_valid && pend_kind == $past(bus_kind))); // R5

    AST_NO_REPLACE: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_valid && bus_req) |=> $stable(pend_kind)); // R6

    AST_PKT_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_valid && (ev_pkt_rx || ev_pkt_tx)) |=> !pend_valid); // R7

    AST_GAP_KEEPS_FAIR_PRI: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_valid && (pend_kind == BK_FAIR || pend_kind == BK_PRI) && ev_subgap
         && !ev_pkt_rx && !ev_pkt_tx && !ev_bus_reset) |=> pend_valid); // R8

    AST_BRST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ev_bus_reset |=> (!pend_valid && !accel_on)); // R9

    AST_ACCEL_ISO: assert property (@(posedge clk) disable iff (!rst_n)
        accel_on |-> (pend_valid && pend_kind == BK_ISO)); // R10

endmodule

// File: rtl/link_req_handler.sv
// Link request handler top: decodes the request code and steers it to the
// register file, the read response stage or the bus request holder.
// Assumes req_kind is meaningful only while req_valid is high.
module link_req_handler
    import lrh_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 8,
    parameter int PHYID_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [2:0]         req_kind,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_data,
    input  logic               ev_pkt_rx,
    input  logic               ev_pkt_tx,
    input  logic               ev_subgap,
    input  logic               ev_bus_reset,
    input  logic               selfid_load,
    input  logic [PHYID_W-1:0] selfid_id,
    input  logic               rsp_ready,
    output logic               rsp_valid,
    output logic [ADDR_W-1:0]  rsp_addr,
    output logic [DATA_W-1:0]  rsp_data,
    output logic               proto_err,
    output logic               pend_valid,
    output logic [1:0]         pend_kind,
    output logic               accel_on
);

    logic              wr_en;
    logic              rd_req;
    logic              bus_req;
    bus_kind_e         bus_kind;
    bus_kind_e         pend_kind_e;
    logic [DATA_W-1:0] rd_data;

    // Decode the request code into one strobe per consumer.
    always_comb begin
        wr_en    = 1'b0;
        rd_req   = 1'b0;
        bus_req  = 1'b0;
        bus_kind = BK_FAIR;
        if (req_valid) begin
            case (req_kind)
                LK_WRITE: wr_en = 1'b1;
                LK_READ:  rd_req = 1'b1;
                LK_FAIR:  begin bus_req = 1'b1; bus_kind = BK_FAIR; end
                LK_PRI:   begin bus_req = 1'b1; bus_kind = BK_PRI;  end
                LK_ISO:   begin bus_req = 1'b1; bus_kind = BK_ISO;  end
                LK_IMM:   begin bus_req = 1'b1; bus_kind = BK_IMM;  end
                default:  ;
            endcase
        end
    end

    lrh_regfile #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .PHYID_W (PHYID_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (req_addr),
        .wr_data  (req_data),
        .id_load  (selfid_load),
        .id_value (selfid_id),
        .rd_addr  (req_addr),
        .rd_data  (rd_data)
    );

    lrh_readrsp #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_rsp (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_req    (rd_req),
        .rd_addr   (req_addr),
        .rd_data   (rd_data),
        .rsp_ready (rsp_ready),
        .rsp_valid (rsp_valid),
        .rsp_addr  (rsp_addr),
        .rsp_data  (rsp_data),
        .proto_err (proto_err)
    );

    lrh_busreq u_bus (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_req      (bus_req),
        .bus_kind     (bus_kind),
        .ev_pkt_rx    (ev_pkt_rx),
        .ev_pkt_tx    (ev_pkt_tx),
        .ev_subgap    (ev_subgap),
        .ev_bus_reset (ev_bus_reset),
        .pend_valid   (pend_valid),
        .pend_kind    (pend_kind_e),
        .accel_on     (accel_on)
    );

    assign pend_kind = pend_kind_e;

    AST_ODD_CODE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind > 3'd5 && !pend_valid && !rsp_valid) |=>
            (!pend_valid && !rsp_valid)); // R11

endmodule

// File: tb/sim_link_req_handler.sv
module sim_link_req_handler;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [2:0] req_kind = 3'd0;
    logic [3:0] req_addr = 4'd0;
    logic [7:0] req_data = 8'd0;
    logic       ev_pkt_rx = 1'b0, ev_pkt_tx = 1'b0, ev_subgap = 1'b0, ev_bus_reset = 1'b0;
    logic       selfid_load = 1'b0;
    logic [5:0] selfid_id = 6'd0;
    logic       rsp_ready = 1'b0;
    logic       rsp_valid, proto_err, pend_valid, accel_on;
    logic [3:0] rsp_addr;
    logic [7:0] rsp_data;
    logic [1:0] pend_kind;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    link_req_handler u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_data(req_data), .ev_pkt_rx(ev_pkt_rx),
        .ev_pkt_tx(ev_pkt_tx), .ev_subgap(ev_subgap), .ev_bus_reset(ev_bus_reset),
        .selfid_load(selfid_load), .selfid_id(selfid_id), .rsp_ready(rsp_ready),
        .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_data(rsp_data),
        .proto_err(proto_err), .pend_valid(pend_valid), .pend_kind(pend_kind),
        .accel_on(accel_on)
    );

    // Vector: {req code (7 = no request), events {rx,tx,gap,reset}, exp pend, exp kind, exp accel}
    localparam int NV = 19;
    localparam logic [10:0] VEC [NV] = '{
        {3'd2, 4'b0000, 1'b1, 2'd0, 1'b0},  // R5 fair accepted
        {3'd4, 4'b0000, 1'b1, 2'd0, 1'b0},  // R6 iso ignored
        {3'd7, 4'b0010, 1'b1, 2'd0, 1'b0},  // R8 gap keeps fair
        {3'd7, 4'b1000, 1'b0, 2'd0, 1'b0},  // R7 rx cancels
        {3'd4, 4'b0000, 1'b1, 2'd2, 1'b1},  // R10 iso sets accel
        {3'd5, 4'b0000, 1'b1, 2'd2, 1'b1},  // R6 imm ignored
        {3'd7, 4'b0010, 1'b0, 2'd0, 1'b0},  // R8 gap cancels iso, R10
        {3'd5, 4'b0000, 1'b1, 2'd3, 1'b0},  // R5 imm, no accel
        {3'd7, 4'b0010, 1'b0, 2'd0, 1'b0},  // R8 gap cancels imm
        {3'd3, 4'b0000, 1'b1, 2'd1, 1'b0},  // R5 pri
        {3'd7, 4'b0010, 1'b1, 2'd1, 1'b0},  // R8 gap keeps pri
        {3'd7, 4'b0100, 1'b0, 2'd0, 1'b0},  // R7 tx cancels
        {3'd4, 4'b0000, 1'b1, 2'd2, 1'b1},  // R10 iso
        {3'd7, 4'b0001, 1'b0, 2'd0, 1'b0},  // R9 reset clears
        {3'd3, 4'b0001, 1'b0, 2'd0, 1'b0},  // R9 request dropped by reset
        {3'd3, 4'b0000, 1'b1, 2'd1, 1'b0},  // R5 pri
        {3'd2, 4'b1000, 1'b0, 2'd0, 1'b0},  // R7 request on cancel edge ignored
        {3'd4, 4'b0000, 1'b1, 2'd2, 1'b1},  // R10 iso
        {3'd7, 4'b0100, 1'b0, 2'd0, 1'b0}   // R10 tx cancel drops accel
    };

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        req_valid = 1'b0; req_kind = 3'd0; req_addr = 4'd0; req_data = 8'd0;
        ev_pkt_rx = 1'b0; ev_pkt_tx = 1'b0; ev_subgap = 1'b0; ev_bus_reset = 1'b0;
        selfid_load = 1'b0;
    endtask

    task automatic do_req(input logic [2:0] k, input logic [3:0] a, input logic [7:0] d);
        req_valid = 1'b1; req_kind = k; req_addr = a; req_data = d;
        tick();
        idle_inputs();
    endtask

    // Issue a read, check the response the next cycle, then take it.
    task automatic read_check(input string req, input logic [3:0] a, input int exp);
        do_req(3'd1, a, 8'd0);
        check(req, int'(rsp_valid), 1);
        check(req, int'(rsp_addr), int'(a));
        check(req, int'(rsp_data), exp);
        rsp_ready = 1'b1;
        tick();
        rsp_ready = 1'b0;
        check(req, int'(rsp_valid), 0);
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        tick(); tick();
        rst_n = 1'b1;
        tick();
        // reset state
        check("R5 reset pend", int'(pend_valid), 0);
        check("R10 reset accel", int'(accel_on), 0);
        check("R3 reset rsp", int'(rsp_valid), 0);
        check("R4 reset err", int'(proto_err), 0);
        read_check("R1 reset reg", 4'd9, 8'h00);

        // table of bus request steps
        for (int i = 0; i < NV; i++) begin
            logic [10:0] v;
            v = VEC[i];
            req_valid = (v[10:8] != 3'd7);
            req_kind = v[10:8];
            {ev_pkt_rx, ev_pkt_tx, ev_subgap, ev_bus_reset} = v[7:4];
            tick();
            idle_inputs();
            check($sformatf("R5-step%0d pend", i), int'(pend_valid), int'(v[3]));
            if (v[3]) check($sformatf("R6 step%0d kind", i), int'(pend_kind), int'(v[2:1]));
            check($sformatf("R10 step%0d accel", i), int'(accel_on), int'(v[0]));
        end

        // R1 write then read
        do_req(3'd0, 4'd5, 8'hA5);
        read_check("R1 write lands", 4'd5, 8'hA5);
        do_req(3'd0, 4'd15, 8'h5A);
        read_check("R1 top address", 4'd15, 8'h5A);

        // R2 register 0 split
        do_req(3'd0, 4'd0, 8'hFF);
        read_check("R2 link write low only", 4'd0, 8'h03);
        selfid_id = 6'h2A; selfid_load = 1'b1;
        tick();
        idle_inputs();
        read_check("R2 id load", 4'd0, 8'hAB);
        do_req(3'd0, 4'd0, 8'h00);
        read_check("R2 id kept", 4'd0, 8'hA8);

        // R3 hold under stall, captured data survives a write
        do_req(3'd1, 4'd5, 8'd0);
        do_req(3'd0, 4'd5, 8'h3C);
        for (int j = 0; j < 3; j++) begin
            check("R3 hold valid", int'(rsp_valid), 1);
            check("R3 hold data", int'(rsp_data), 8'hA5);
            tick();
        end
        // R4 overlapping read
        do_req(3'd1, 4'd15, 8'd0);
        check("R4 err pulse", int'(proto_err), 1);
        check("R4 addr kept", int'(rsp_addr), 5);
        check("R4 data kept", int'(rsp_data), 8'hA5);
        tick();
        check("R4 err one cycle", int'(proto_err), 0);
        rsp_ready = 1'b1;
        tick();
        rsp_ready = 1'b0;
        check("R3 retired", int'(rsp_valid), 0);
        read_check("R1 later write", 4'd5, 8'h3C);

        // R11 unused codes
        do_req(3'd6, 4'd5, 8'h77);
        check("R11 code6 pend", int'(pend_valid), 0);
        check("R11 code6 rsp", int'(rsp_valid), 0);
        do_req(3'd7, 4'd5, 8'h77);
        check("R11 code7 pend", int'(pend_valid), 0);
        read_check("R11 reg untouched", 4'd5, 8'h3C);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule